// File: doc/BRIEF.md
# First-Fault Vector Gather Load Unit

This block is a sequencer that fills one vector register from scattered memory locations. A start pulse captures a configuration, a scalar base address, a vector of per-lane offsets and a byte-granular predicate. The unit then steps through the element lanes from lowest to highest. For each active lane it computes an address, issues a single memory read, and extends the returned value to the element width. Inactive lanes produce zero and cause no memory traffic. The finished register image is presented on a write port with per-byte enables.

The unit keeps speculative loads safe. A fault on the first active lane is reported to the core as a real exception: the fault output carries the address, and nothing is written. A fault on any later active lane raises no exception. The load stops at that lane, only the lanes below it are written, and the first-fault mask clears its bytes from that lane upward. Software uses that mask to tell how far the load got.

Top module: `gff_gather_unit`

## Requirements
- R1: The configuration is rejected when any of these holds:
  - the offset mode is 3 (reserved), or the offset mode is 2 (64-bit) with 32-bit elements;
  - the memory size is 3 with 32-bit elements;
  - a signed load is requested whose memory size equals the element size (2 for 32-bit elements, 3 for 64-bit elements).

  A rejected start pulses `cfg_err_o` one cycle after the start. It issues no request, asserts no `done_o` and leaves `ffr_o` unchanged.
- R2: Lanes are visited in ascending order, with at most one memory request outstanding. Lane i is active when predicate bit 4*i is set (32-bit elements) or bit 8*i is set (64-bit elements). Only active lanes raise `req_o`. The signal `req_o` is high in the cycle the lane is visited and drops until the response arrives.
- R3: The request address is the base plus the extended offset shifted left by `scale_i`. The offset for lane i is taken from bits [32*i +: 32] for 32-bit elements and bits [64*i +: 64] for 64-bit elements. Offset mode 0 zero-extends the low 32 bits of the lane, mode 1 sign-extends them, and mode 2 uses all 64 bits. `size_o` equals `msize_i`, where 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R4: The returned data is cut to the memory size and then zero-extended or sign-extended (when `signed_i` is set) to the element width.
- R5: Every inactive lane is written as zero.
- R6: When the last lane is done without a fault, `done_o` and `wr_en_o` pulse together, `wr_be_o` is all ones, and `ffr_o` is all ones. This happens one cycle after the final response, plus one cycle for each inactive lane that follows the last active lane. With no active lane it happens one cycle per lane plus one after the start.
- R7: A fault on the first active lane pulses `fault_o` one cycle after that response, with `fault_addr_o` holding the request address. There is no write and no `done_o`, and `ffr_o` is unchanged.
- R8: A fault on a later active lane L ends the load one cycle after that response with `done_o` and `wr_en_o`. Both `wr_be_o` and `ffr_o` have ones exactly on the bytes below lane L's first byte. No further request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| elem64_i | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| msize_i | input | 2 | Memory access size code |
| signed_i | input | 1 | Sign-extend loaded data |
| off_mode_i | input | 2 | Offset mode: 0 u32, 1 s32, 2 64-bit |
| scale_i | input | 2 | Left shift applied to the offset |
| base_i | input | 64 | Scalar base address |
| offs_i | input | 128*VL_QUADS | Offset vector |
| pred_i | input | 16*VL_QUADS | Byte predicate |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Load completed or truncated |
| cfg_err_o | output | 1 | Illegal configuration rejected |
| fault_o | output | 1 | Real fault on the first active lane |
| fault_addr_o | output | 64 | Address of the real fault |
| req_o | output | 1 | Memory read request |
| addr_o | output | 64 | Request address |
| size_o | output | 2 | Request size code |
| rvalid_i | input | 1 | Memory response valid |
| rdata_i | input | 64 | Response data |
| rfault_i | input | 1 | Response would fault |
| wr_en_o | output | 1 | Destination write strobe |
| wr_data_o | output | 128*VL_QUADS | Destination register image |
| wr_be_o | output | 16*VL_QUADS | Destination byte enables |
| ffr_o | output | 16*VL_QUADS | First-fault mask |

## Verification
The bench counts falling edges from the start pulse and computes when each result is due:
- `cfg_err_o` is due one cycle after the start.
- `req_o` is due in the cycle its lane is visited. The bench returns each response one cycle after seeing the request.
- `fault_o` is due one cycle after the faulting response.
- `done_o` is due one cycle after the response that ends the run, plus one cycle per trailing inactive lane.

All outputs are sampled on the falling edge. Each result is compared against its predicted cycle, so a result that arrives early or late is reported even when its value is right. The sweep covers every element width, memory size, signedness, offset mode and scale.

// File: rtl/gff_pkg.sv
package gff_pkg;
  localparam int ADDR_W = 64;

  typedef enum logic [1:0] {
    OFF_U32 = 2'd0,
    OFF_S32 = 2'd1,
    OFF_X64 = 2'd2,
    OFF_RSV = 2'd3
  } off_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WAIT,
    ST_DONE,
    ST_FAULT,
    ST_CERR
  } gff_st_e;

  function automatic logic cfg_legal(logic e64, logic [1:0] msz, logic sgn, logic [1:0] mode);
    logic ok;
    ok = 1'b1;
    if (mode == OFF_RSV) ok = 1'b0;
    if (mode == OFF_X64 && !e64) ok = 1'b0;
    if (msz == 2'd3 && !e64) ok = 1'b0;
    if (sgn && (msz == (e64 ? 2'd3 : 2'd2))) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/gff_lane_pick.sv
module gff_lane_pick #(
  parameter int VLEN = 256,
  parameter int LW   = 3
) (
  input  logic [VLEN-1:0]   offs_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic              elem64_i,
  input  logic [LW-1:0]     lane_i,
  output logic [63:0]       off_o,
  output logic              act_o
);
  localparam int LW64 = LW - 1;

  logic [LW64-1:0] lane64;
  assign lane64 = lane_i[LW64-1:0];

  always_comb begin
    if (elem64_i) begin
      off_o = offs_i[64*int'(lane64) +: 64];
      act_o = pred_i[8*int'(lane64)];
    end else begin
      off_o = {32'b0, offs_i[32*int'(lane_i) +: 32]};
      act_o = pred_i[4*int'(lane_i)];
    end
  end
endmodule

// File: rtl/gff_addr_gen.sv
module gff_addr_gen
  import gff_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  logic [63:0]       off_i,
  input  off_mode_e         mode_i,
  input  logic [1:0]        scale_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [63:0] off_ext;

  always_comb begin
    unique case (mode_i)
      OFF_U32: off_ext = {32'b0, off_i[31:0]};
      OFF_S32: off_ext = {{32{off_i[31]}}, off_i[31:0]};
      default: off_ext = off_i;
    endcase
    addr_o = base_i + (off_ext << scale_i);
  end
endmodule

// File: rtl/gff_extend.sv
module gff_extend (
  input  logic [63:0] data_i,
  input  logic [1:0]  msize_i,
  input  logic        signed_i,
  output logic [63:0] ext_o
);
  always_comb begin
    unique case (msize_i)
      2'd0: ext_o = {{56{signed_i & data_i[7]}},  data_i[7:0]};
      2'd1: ext_o = {{48{signed_i & data_i[15]}}, data_i[15:0]};
      2'd2: ext_o = {{32{signed_i & data_i[31]}}, data_i[31:0]};
      default: ext_o = data_i;
    endcase
  end
endmodule

// File: rtl/gff_gather_unit.sv
module gff_gather_unit
  import gff_pkg::*;
#(
  parameter int VL_QUADS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    elem64_i,
  input  logic [1:0]              msize_i,
  input  logic                    signed_i,
  input  logic [1:0]              off_mode_i,
  input  logic [1:0]              scale_i,
  input  logic [63:0]             base_i,
  input  logic [128*VL_QUADS-1:0] offs_i,
  input  logic [16*VL_QUADS-1:0]  pred_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    cfg_err_o,
  output logic                    fault_o,
  output logic [63:0]             fault_addr_o,
  output logic                    req_o,
  output logic [63:0]             addr_o,
  output logic [1:0]              size_o,
  input  logic                    rvalid_i,
  input  logic [63:0]             rdata_i,
  input  logic                    rfault_i,
  output logic                    wr_en_o,
  output logic [128*VL_QUADS-1:0] wr_data_o,
  output logic [16*VL_QUADS-1:0]  wr_be_o,
  output logic [16*VL_QUADS-1:0]  ffr_o
);
  localparam int VLEN = 128 * VL_QUADS;
  localparam int VB   = VLEN / 8;
  localparam int NL32 = VLEN / 32;
  localparam int NL64 = VLEN / 64;
  localparam int LW   = $clog2(NL32);
  localparam int LW64 = LW - 1;
  localparam int BW   = $clog2(VB) + 1;

  gff_st_e         st_q;
  logic [LW-1:0]   lane_q;
  logic            e64_q, sgn_q, first_q;
  logic [1:0]      msz_q, scl_q;
  off_mode_e       mode_q;
  logic [63:0]     base_q, fault_addr_q;
  logic [VLEN-1:0] offs_q, buf_q;
  logic [VB-1:0]   pred_q, be_q, ffr_q, cut_mask;

  logic [63:0]     off_raw, addr, ext;
  logic            lane_act, lane_last;
  logic [LW-1:0]   last_lane;
  logic [BW-1:0]   bound;

  gff_lane_pick #(.VLEN(VLEN), .LW(LW)) u_pick (
    .offs_i   (offs_q),
    .pred_i   (pred_q),
    .elem64_i (e64_q),
    .lane_i   (lane_q),
    .off_o    (off_raw),
    .act_o    (lane_act)
  );

  gff_addr_gen u_agen (
    .base_i  (base_q),
    .off_i   (off_raw),
    .mode_i  (mode_q),
    .scale_i (scl_q),
    .addr_o  (addr)
  );

  gff_extend u_ext (
    .data_i   (rdata_i),
    .msize_i  (msz_q),
    .signed_i (sgn_q),
    .ext_o    (ext)
  );

  assign last_lane = e64_q ? LW'(NL64 - 1) : LW'(NL32 - 1);
  assign lane_last = (lane_q == last_lane);
  assign bound     = e64_q ? BW'({lane_q, 3'b000}) : BW'({lane_q, 2'b00});

  // bytes kept on truncation: everything below the faulting lane
  for (genvar b = 0; b < VB; b++) begin : g_cut
    assign cut_mask[b] = (BW'(b) < bound);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      lane_q       <= '0;
      e64_q        <= 1'b0;
      sgn_q        <= 1'b0;
      first_q      <= 1'b0;
      msz_q        <= '0;
      scl_q        <= '0;
      mode_q       <= OFF_U32;
      base_q       <= '0;
      fault_addr_q <= '0;
      offs_q       <= '0;
      buf_q        <= '0;
      pred_q       <= '0;
      be_q         <= '0;
      ffr_q        <= '1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cfg_legal(elem64_i, msize_i, signed_i, off_mode_i)) begin
              e64_q   <= elem64_i;
              msz_q   <= msize_i;
              sgn_q   <= signed_i;
              mode_q  <= off_mode_e'(off_mode_i);
              scl_q   <= scale_i;
              base_q  <= base_i;
              offs_q  <= offs_i;
              pred_q  <= pred_i;
              lane_q  <= '0;
              first_q <= 1'b1;
              buf_q   <= '0;
              st_q    <= ST_SCAN;
            end else begin
              st_q <= ST_CERR;
            end
          end
        end
        ST_SCAN: begin
          if (lane_act) begin
            st_q <= ST_WAIT;
          end else if (lane_last) begin
            be_q  <= '1;
            ffr_q <= '1;
            st_q  <= ST_DONE;
          end else begin
            lane_q <= lane_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (rvalid_i) begin
            if (rfault_i) begin
              if (first_q) begin
                fault_addr_q <= addr;
                st_q         <= ST_FAULT;
              end else begin
                be_q  <= cut_mask;
                ffr_q <= cut_mask;
                st_q  <= ST_DONE;
              end
            end else begin
              if (e64_q) buf_q[64*int'(lane_q[LW64-1:0]) +: 64] <= ext;
              else       buf_q[32*int'(lane_q) +: 32]          <= ext[31:0];
              first_q <= 1'b0;
              if (lane_last) begin
                be_q  <= '1;
                ffr_q <= '1;
                st_q  <= ST_DONE;
              end else begin
                lane_q <= lane_q + 1'b1;
                st_q   <= ST_SCAN;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign wr_en_o      = (st_q == ST_DONE);
  assign fault_o      = (st_q == ST_FAULT);
  assign cfg_err_o    = (st_q == ST_CERR);
  assign fault_addr_o = fault_addr_q;
  assign req_o        = (st_q == ST_SCAN) && lane_act;
  assign addr_o       = addr;
  assign size_o       = msz_q;
  assign wr_data_o    = buf_q;
  assign wr_be_o      = be_q;
  assign ffr_o        = ffr_q;
endmodule

// File: rtl/gff_gather_unit_chk.sv
module gff_gather_unit_chk #(
  parameter int VL_QUADS = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   cfg_err_o,
  input logic                   fault_o,
  input logic                   req_o,
  input logic                   wr_en_o,
  input logic [16*VL_QUADS-1:0] ffr_o
);
  p_cfg_err_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(start_i) && !$past(busy_o));

  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  p_req_only_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);

  p_write_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);

  p_done_to_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_fault_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !done_o && !wr_en_o);

  p_fault_to_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !busy_o);

  p_ffr_moves_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ffr_o) |-> done_o);
endmodule

bind gff_gather_unit gff_gather_unit_chk #(.VL_QUADS(VL_QUADS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cfg_err_o (cfg_err_o),
  .fault_o   (fault_o),
  .req_o     (req_o),
  .wr_en_o   (wr_en_o),
  .ffr_o     (ffr_o)
);

// File: tb/gff_gather_unit_tb_top.sv
module gff_gather_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int VLQ   = 2;
  localparam int VLEN  = 128 * VLQ;
  localparam int VB    = VLEN / 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, elem64_i = 1'b0, signed_i = 1'b0;
  logic [1:0] msize_i = '0, off_mode_i = '0, scale_i = '0;
  logic [63:0] base_i = '0;
  logic [VLEN-1:0] offs_i = '0;
  logic [VB-1:0] pred_i = '0;
  logic busy_o, done_o, cfg_err_o, fault_o, req_o, wr_en_o;
  logic [63:0] fault_addr_o, addr_o;
  logic [1:0] size_o;
  logic rvalid_i = 1'b0, rfault_i = 1'b0;
  logic [63:0] rdata_i = '0;
  logic [VLEN-1:0] wr_data_o;
  logic [VB-1:0] wr_be_o, ffr_o;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  logic [VB-1:0] exp_ffr = '1;

  always #(CLK_P/2) clk = ~clk;

  gff_gather_unit #(.VL_QUADS(VLQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .elem64_i(elem64_i),
    .msize_i(msize_i), .signed_i(signed_i), .off_mode_i(off_mode_i),
    .scale_i(scale_i), .base_i(base_i), .offs_i(offs_i), .pred_i(pred_i),
    .busy_o(busy_o), .done_o(done_o), .cfg_err_o(cfg_err_o), .fault_o(fault_o),
    .fault_addr_o(fault_addr_o), .req_o(req_o), .addr_o(addr_o), .size_o(size_o),
    .rvalid_i(rvalid_i), .rdata_i(rdata_i), .rfault_i(rfault_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .ffr_o(ffr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_data(logic [63:0] a);
    return {a[31:0] ^ 32'h9E37_79B9, ~a[31:0] ^ {a[7:0], a[31:8]}};
  endfunction

  function automatic bit mem_fault(logic [63:0] a);
    return a[11:8] == 4'hF;
  endfunction

  function automatic logic [63:0] bext(logic [63:0] d, logic [1:0] ms, bit s);
    int nb;
    logic [63:0] r;
    nb = 8 << ms;
    for (int b = 0; b < 64; b++) r[b] = (b < nb) ? d[b] : (s & d[nb-1]);
    return r;
  endfunction

  function automatic bit legal(bit e64, logic [1:0] ms, bit s, logic [1:0] md);
    if (md == 2'd3) return 0;
    if (md == 2'd2 && !e64) return 0;
    if (ms == 2'd3 && !e64) return 0;
    if (s && ms == (e64 ? 2'd3 : 2'd2)) return 0;
    return 1;
  endfunction

  task automatic run_op(input bit e64, input logic [1:0] ms, input bit s, input logic [1:0] md,
                        input logic [1:0] sc, input logic [63:0] base,
                        input logic [VLEN-1:0] offs, input logic [VB-1:0] pred);
    int nl, esz, kind, n_act, lastact, cut, m, cnt, last_evt, nreq;
    bit first, fin, resp_pend;
    logic [63:0] exp_addr [16];
    logic [63:0] a, o, flt_addr, raddr;
    logic [VLEN-1:0] exp_buf, bmask;
    logic [VB-1:0] exp_be, new_ffr;
    nl = e64 ? VLEN/64 : VLEN/32;
    esz = e64 ? 8 : 4;
    kind = 0; n_act = 0; lastact = -1; cut = 0; first = 1; exp_buf = '0;
    flt_addr = '0;
    if (!legal(e64, ms, s, md)) kind = 3;
    else begin
      for (int i = 0; i < nl; i++) begin
        if (!pred[i*esz]) continue;
        o = e64 ? offs[i*64 +: 64] : {32'b0, offs[i*32 +: 32]};
        if (md == 2'd0) o = {32'b0, o[31:0]};
        else if (md == 2'd1) o = {{32{o[31]}}, o[31:0]};
        a = base + (o << sc);
        exp_addr[n_act] = a;
        n_act++;
        if (mem_fault(a)) begin
          if (first) begin kind = 2; flt_addr = a; end
          else begin kind = 1; cut = i; end
          break;
        end
        if (e64) exp_buf[i*64 +: 64] = bext(mem_data(a), ms, s);
        else     exp_buf[i*32 +: 32] = bext(mem_data(a), ms, s) >> 0;
        first = 0;
        lastact = i;
      end
    end
    m = (kind == 0) ? (nl - 1 - lastact) : 0;
    if (kind == 1) for (int b = 0; b < VB; b++) exp_be[b] = (b < cut*esz);
    else exp_be = '1;
    new_ffr = exp_be;

    @(negedge clk);
    elem64_i = e64; msize_i = ms; signed_i = s; off_mode_i = md; scale_i = sc;
    base_i = base; offs_i = offs; pred_i = pred; start_i = 1'b1;
    cnt = 0; last_evt = 0; nreq = 0; fin = 0; resp_pend = 0; raddr = '0;
    while (!fin && cnt < 300) begin
      @(negedge clk);
      cnt++;
      start_i = 1'b0;
      rvalid_i = 1'b0; rfault_i = 1'b0;
      if (resp_pend) begin
        rvalid_i = 1'b1; rdata_i = mem_data(raddr); rfault_i = mem_fault(raddr);
        resp_pend = 0; last_evt = cnt;
      end
      if (req_o) begin
        // R2 R3: request order, address and size
        chk(nreq < n_act, "R2 unexpected request", VLEN'(nreq), VLEN'(n_act));
        if (nreq < n_act) chk(addr_o == exp_addr[nreq], "R3 address", VLEN'(addr_o), VLEN'(exp_addr[nreq]));
        chk(size_o == ms, "R3 size", VLEN'(size_o), VLEN'(ms));
        raddr = addr_o; nreq++; resp_pend = 1;
      end
      if (cfg_err_o) begin
        chk(kind == 3 && cnt == 1, "R1 cfg error timing", VLEN'(cnt), VLEN'(1));
        fin = 1;
      end
      if (fault_o) begin
        chk(kind == 2 && cnt == last_evt + 1, "R7 fault timing", VLEN'(cnt), VLEN'(last_evt + 1));
        chk(fault_addr_o == flt_addr, "R7 fault address", VLEN'(fault_addr_o), VLEN'(flt_addr));
        chk(!wr_en_o && ffr_o == exp_ffr, "R7 no write, mask kept", VLEN'(ffr_o), VLEN'(exp_ffr));
        fin = 1;
      end
      if (done_o) begin
        chk((kind == 0 || kind == 1) && cnt == last_evt + m + 1, "R6 done timing",
            VLEN'(cnt), VLEN'(last_evt + m + 1));
        chk(wr_en_o && wr_be_o == exp_be, kind == 1 ? "R8 byte enables" : "R6 byte enables",
            VLEN'(wr_be_o), VLEN'(exp_be));
        for (int b = 0; b < VB; b++) bmask[b*8 +: 8] = {8{exp_be[b]}};
        chk((wr_data_o & bmask) == (exp_buf & bmask), "R4 R5 written data",
            wr_data_o & bmask, exp_buf & bmask);
        chk(ffr_o == new_ffr, kind == 1 ? "R8 first-fault mask" : "R6 first-fault mask",
            VLEN'(ffr_o), VLEN'(new_ffr));
        exp_ffr = new_ffr;
        fin = 1;
      end
    end
    chk(fin, "R6 operation never ended", VLEN'(cnt), '0);
    @(negedge clk);
    rvalid_i = 1'b0;
    chk(nreq == ((kind == 3) ? 0 : n_act), kind == 3 ? "R1 no requests" : "R8 request count",
        VLEN'(nreq), VLEN'(n_act));
    chk(!busy_o && !req_o && ffr_o == exp_ffr, "R1 idle after op, mask", VLEN'(ffr_o), VLEN'(exp_ffr));
  endtask

  initial begin
    logic [VLEN-1:0] offs;
    logic [VB-1:0] pred;
    repeat (3) @(negedge clk);
    chk(ffr_o == '1 && !busy_o && !done_o && !req_o && !fault_o, "R6 reset state", VLEN'(ffr_o), VLEN'({VB{1'b1}}));
    rst_ni = 1'b1;
    // R7 directed: first active lane faults
    run_op(0, 2'd2, 0, 2'd0, 2'd0, 64'hF00, '0, '1);
    // R8 directed: lane 3 faults after three good lanes
    offs = '0; offs[3*32 +: 32] = 32'hE00;
    run_op(0, 2'd2, 0, 2'd0, 2'd0, 64'h100, offs, '1);
    // R5 directed: empty predicate
    run_op(1, 2'd1, 1, 2'd2, 2'd1, 64'h2000, '0, '0);
    for (int e = 0; e < 2; e++)
      for (int ms = 0; ms < 4; ms++)
        for (int s = 0; s < 2; s++)
          for (int md = 0; md < 4; md++)
            for (int sc = 0; sc < 4; sc++)
              for (int r = 0; r < 4; r++) begin
                for (int w = 0; w < VLEN/32; w++) offs[w*32 +: 32] = $urandom;
                pred = r == 0 ? '1 : r == 1 ? VB'({$urandom}) : r == 2 ? VB'({$urandom} & {$urandom}) : '0;
                run_op(e[0], ms[1:0], s[0], md[1:0], sc[1:0], {$urandom, $urandom}, offs, pred);
              end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule